// File: doc/BRIEF.md
# Contiguous Run Slot Allocator

This block hands out runs of consecutive fixed-size slots from a circular pool. A client asks for between one and `MAX_RUN` slots. The block answers with the index of the first slot, the byte offset of that slot and the absolute address (a base plus the offset). A grant is always contiguous. When the run would not fit between the free pointer and the end of the pool, the block places it at slot 0 instead of splitting it. The pool holds `MAX_RUN - 1` slots beyond the nominal `SLOT_COUNT`, so a run that starts below `SLOT_COUNT` never needs to cross the end.

Before it reports a grant, the block clears each slot of the run in the backing RAM through its own write port, one slot per cycle. During those writes it holds `busy` high and refuses new requests. The slot stride can be rounded up to a power of two for pools that DMA engines read, so that no element straddles a power-of-two boundary. A separate combinational query returns the slot that follows a given one and wraps to 0 at the end of the pool. That query is meaningful only for single-slot pools.

Top module: `slot_pool_alloc`

## Requirements
- R1: The configuration is faulty when `ELEM_BYTES` is 0, when `MAX_RUN` is 0, or when `SLOT_COUNT` < `MAX_RUN`. A faulty configuration drives `cfg_fault` to 1 and holds `req_ready` at 0.
- R2: The pool capacity CAP is `SLOT_COUNT + MAX_RUN - 1` slots. A run of length n is granted in place when n <= CAP - free pointer, which includes a run that ends exactly at CAP.
- R3: When n > CAP - free pointer, the run is granted at slot 0. No granted run ever extends past slot CAP-1.
- R4: After each grant the free pointer equals the start slot plus n. `rsp_offset` = start slot × stride, and `rsp_addr` = `BASE_ADDR` + `rsp_offset`.
- R5: A grant accepted at clock edge E drives `mem_we` during the n cycles that follow E. Those writes go to ascending slots, starting at the start slot, with `mem_wdata` = 0. `busy` stays 1 and `req_ready` stays 0 during the writes. `rsp_valid` pulses for one cycle right after the last write.
- R6: An accepted request with count 0 or count > `MAX_RUN` pulses `req_err` for one cycle in the cycle after acceptance. It causes no RAM write and leaves the free pointer unchanged, which shows in the slot of the next grant.
- R7: The slot stride is `ELEM_BYTES` when `DMA_ROUND` = 0. When `DMA_ROUND` = 1, the stride is the smallest power of two that is >= `ELEM_BYTES`.
- R8: `nq_next` = `nq_slot` + 1, or 0 when `nq_slot` + 1 >= CAP. `nq_err` = 1 when `MAX_RUN` != 1 or when `nq_slot` >= CAP.
- R9: After reset the free pointer is 0, `busy`, `rsp_valid` and `req_err` are 0, and `req_ready` is 1 (for a valid configuration).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fault | output | 1 | Parameter set rejected |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_count | input | CNT_W | Number of slots asked for |
| req_err | output | 1 | One-cycle pulse for an out-of-range count |
| rsp_valid | output | 1 | One-cycle pulse: grant cleared and reported |
| rsp_slot | output | IDX_W | First slot of the grant |
| rsp_offset | output | ADDR_W | Byte offset of the first slot |
| rsp_addr | output | ADDR_W | BASE_ADDR plus offset |
| busy | output | 1 | Clearing writes in progress |
| mem_we | output | 1 | Backing RAM write enable |
| mem_waddr | output | IDX_W | Slot being cleared |
| mem_wdata | output | DATA_W | Write data (all zero) |
| nq_slot | input | IDX_W | Slot for the next-slot query |
| nq_next | output | IDX_W | Slot that follows nq_slot |
| nq_err | output | 1 | Query not valid for this pool |

## Verification
The hardest case is a run that ends exactly on the last physical slot, followed at once by a request that has to skip back to slot 0. Reaching it takes a request sequence whose running sum lands exactly on CAP. The stimulus chains runs of lengths 3, 4, 4 and 2 in a 13-slot pool to land there, then asks for one more slot. A rejected request is placed between valid ones, so a pointer that moved by mistake would show up as a wrong start slot on the following grant. Each grant is checked against a model RAM that starts filled with a non-zero pattern and gets that pattern back after every check.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;

  // smallest power of two not below v
  function automatic int unsigned pow2_ceil(input int unsigned v);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 31; i++) begin
      if (p < v) p = p << 1;
    end
    return p;
  endfunction

  // parameter set sanity rule
  function automatic logic cfg_is_bad(input int unsigned slots,
                                      input int unsigned max_run,
                                      input int unsigned elem);
    return (elem == 0) || (max_run == 0) || (slots < max_run);
  endfunction

  // slot stride in bytes
  function automatic int unsigned stride_of(input int unsigned elem,
                                            input bit dma_round);
    return dma_round ? pow2_ceil(elem) : elem;
  endfunction

endpackage

// File: rtl/slot_pool_ptr.sv
module slot_pool_ptr #(
  parameter int CAP   = 13,
  parameter int IDX_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] run_len,
  output logic [IDX_W-1:0] start_slot,
  output logic [IDX_W-1:0] free_ptr
);
  logic [IDX_W-1:0] free_q;
  logic [IDX_W-1:0] room;
  logic [IDX_W-1:0] len_ext;
  logic             fits;

  assign len_ext    = IDX_W'(run_len);
  assign room       = IDX_W'(CAP) - free_q;
  assign fits       = (len_ext <= room);
  assign start_slot = fits ? free_q : '0;
  assign free_ptr   = free_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     free_q <= '0;
    else if (take)  free_q <= start_slot + len_ext;
  end

  // R3: the free pointer never passes the physical end
  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_q) <= 32'(CAP));

  // R4: after a grant the pointer sits right after the run
  a_r4_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> 32'(free_q) == 32'($past(start_slot)) + 32'($past(run_len)));
endmodule

// File: rtl/slot_pool_zero.sv
module slot_pool_zero #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] first,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] waddr
);
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] left_q;

  assign busy  = (left_q != '0);
  assign last  = (left_q == CNT_W'(1));
  assign waddr = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      cur_q  <= first;
      left_q <= len;
    end else if (busy) begin
      cur_q  <= cur_q + IDX_W'(1);
      left_q <= left_q - CNT_W'(1);
    end
  end

  // R5: clearing walks upward one slot per cycle
  a_r5_seq_writes: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(last) |-> waddr == $past(waddr) + IDX_W'(1));
endmodule

// File: rtl/slot_pool_next.sv
module slot_pool_next #(
  parameter int CAP    = 13,
  parameter int IDX_W  = 4,
  parameter bit SINGLE = 1'b0
) (
  input  logic [IDX_W-1:0] q_slot,
  output logic [IDX_W-1:0] q_next,
  output logic             q_err
);
  logic [IDX_W:0] succ;

  assign succ   = {1'b0, q_slot} + (IDX_W+1)'(1);
  assign q_next = (succ >= (IDX_W+1)'(CAP)) ? '0 : succ[IDX_W-1:0];
  assign q_err  = !SINGLE || (32'(q_slot) >= 32'(CAP));

  // R8: the answer always names a slot inside the pool
  always_comb begin
    a_r8_next_in_pool: assert (32'(q_next) < 32'(CAP) || CAP == 0);
  end
endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc
  import slot_pool_pkg::*;
#(
  parameter int          SLOT_COUNT = 10,
  parameter int          MAX_RUN    = 4,
  parameter int          ELEM_BYTES = 12,
  parameter bit          DMA_ROUND  = 1'b1,
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h0000_1000,
  localparam int CAP   = SLOT_COUNT + MAX_RUN - 1,
  localparam int IDX_W = $clog2(CAP + 1),
  localparam int CNT_W = $clog2(MAX_RUN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cfg_fault,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_err,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_slot,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              busy,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [IDX_W-1:0]  nq_slot,
  output logic [IDX_W-1:0]  nq_next,
  output logic              nq_err
);
  localparam bit          BAD    = cfg_is_bad(SLOT_COUNT, MAX_RUN, ELEM_BYTES);
  localparam int unsigned STRIDE = stride_of(ELEM_BYTES, DMA_ROUND);

  // named internal events
  logic             accept, count_ok, take, err_fire;
  logic [IDX_W-1:0] start_slot, free_ptr;
  logic             z_busy, z_last;
  logic [IDX_W-1:0] slot_q;
  logic [CNT_W-1:0] len_q;
  logic             rsp_q, err_q;

  assign cfg_fault = BAD;
  assign req_ready = !z_busy && !BAD;
  assign accept    = req_valid && req_ready;
  assign count_ok  = (req_count != '0) && (32'(req_count) <= 32'(MAX_RUN));
  assign take      = accept && count_ok;
  assign err_fire  = accept && !count_ok;

  slot_pool_ptr #(.CAP(CAP), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .take(take), .run_len(req_count),
    .start_slot(start_slot), .free_ptr(free_ptr)
  );

  slot_pool_zero #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_zero (
    .clk(clk), .rst_n(rst_n), .load(take), .first(start_slot), .len(req_count),
    .busy(z_busy), .last(z_last), .waddr(mem_waddr)
  );

  slot_pool_next #(.CAP(CAP), .IDX_W(IDX_W), .SINGLE(MAX_RUN == 1)) u_next (
    .q_slot(nq_slot), .q_next(nq_next), .q_err(nq_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      len_q  <= '0;
      rsp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (take) begin
        slot_q <= start_slot;
        len_q  <= req_count;
      end
      rsp_q <= z_last;
      err_q <= err_fire;
    end
  end

  assign busy       = z_busy;
  assign mem_we     = z_busy;
  assign mem_wdata  = '0;
  assign rsp_valid  = rsp_q;
  assign req_err    = err_q;
  assign rsp_slot   = slot_q;
  assign rsp_offset = ADDR_W'(slot_q) * ADDR_W'(STRIDE);
  assign rsp_addr   = ADDR_W'(BASE_ADDR) + rsp_offset;

  // R3: a reported run stays inside the physical pool
  a_r3_run_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> 32'(rsp_slot) + 32'(len_q) <= 32'(CAP));

  // R5: every clearing write lands inside the run being granted
  a_r5_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr >= slot_q) && (32'(mem_waddr) < 32'(slot_q) + 32'(len_q)));

  // R5: a grant is reported only right after a clearing write
  a_r5_report_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_we) && !mem_we);

  // R6: a rejected count leaves the free pointer alone
  a_r6_err_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> free_ptr == $past(free_ptr));

  // R6: a rejected count starts no clearing
  a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire && !$past(z_busy) |=> !mem_we);
endmodule

// File: tb/slot_pool_alloc_tb.sv
module slot_pool_alloc_tb;
  localparam int CAP_M  = 13;  // 10 + 4 - 1
  localparam int MAXR   = 4;
  localparam int STRD   = 16;  // 12 rounded to power of two
  localparam int BASE_M = 32'h1000;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;  // 200 MHz

  int n_tests = 0;
  int n_fail  = 0;

  logic        cfg_fault, req_valid, req_ready, req_err, rsp_valid, busy, mem_we, nq_err;
  logic [2:0]  req_count;
  logic [3:0]  rsp_slot, mem_waddr, nq_slot, nq_next;
  logic [31:0] rsp_offset, rsp_addr, mem_wdata;

  slot_pool_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fault(cfg_fault), .req_valid(req_valid),
    .req_ready(req_ready), .req_count(req_count), .req_err(req_err),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_offset(rsp_offset),
    .rsp_addr(rsp_addr), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .nq_slot(nq_slot), .nq_next(nq_next), .nq_err(nq_err)
  );

  // single-slot pool: 6 slots, stride 12 kept as is
  logic       s_fault, s_ready, s_err, s_rv, s_busy, s_we, s_nqe;
  logic [2:0] s_slot, s_waddr, s_nq, s_nqn;
  logic [31:0] s_off, s_addr, s_wd;
  slot_pool_alloc #(.SLOT_COUNT(6), .MAX_RUN(1), .ELEM_BYTES(12), .DMA_ROUND(1'b0)) u_single (
    .clk(clk), .rst_n(rst_n), .cfg_fault(s_fault), .req_valid(1'b0),
    .req_ready(s_ready), .req_count(2'd0), .req_err(s_err),
    .rsp_valid(s_rv), .rsp_slot(s_slot), .rsp_offset(s_off),
    .rsp_addr(s_addr), .busy(s_busy), .mem_we(s_we), .mem_waddr(s_waddr),
    .mem_wdata(s_wd), .nq_slot(s_nq), .nq_next(s_nqn), .nq_err(s_nqe)
  );

  // faulty set: fewer slots than the longest run
  logic       b_fault, b_ready, b_err, b_rv, b_busy, b_we, b_nqe;
  logic [2:0] b_slot, b_waddr, b_nqn;
  logic [31:0] b_off, b_addr, b_wd;
  slot_pool_alloc #(.SLOT_COUNT(2), .MAX_RUN(3), .ELEM_BYTES(8)) u_bad (
    .clk(clk), .rst_n(rst_n), .cfg_fault(b_fault), .req_valid(1'b1),
    .req_ready(b_ready), .req_count(3'd1), .req_err(b_err),
    .rsp_valid(b_rv), .rsp_slot(b_slot), .rsp_offset(b_off),
    .rsp_addr(b_addr), .busy(b_busy), .mem_we(b_we), .mem_waddr(b_waddr),
    .mem_wdata(b_wd), .nq_slot(3'd0), .nq_next(b_nqn), .nq_err(b_nqe)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  typedef struct { bit err; int slot; int cnt; } exp_t;
  exp_t sbq[$];
  int   free_m = 0;
  logic [7:0] ram [0:CAP_M-1];
  int   widx = 0;

  // driver: predicts the result, then presents the request
  task automatic send(input int c);
    exp_t e;
    e.cnt = c;
    if (c == 0 || c > MAXR) begin
      e.err = 1; e.slot = 0;
    end else begin
      e.err = 0;
      if (c > CAP_M - free_m) free_m = 0;
      e.slot = free_m;
      free_m += c;
    end
    while (!req_ready) @(negedge clk);
    sbq.push_back(e);
    req_valid = 1; req_count = 3'(c);
    @(negedge clk);
    req_valid = 0; req_count = 0;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: RAM model, write order and grant comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (sbq.size() == 0 || sbq[0].err) chk(0, "R6 stray write", int'(mem_waddr), -1);
        else begin
          chk(mem_waddr == 4'(sbq[0].slot + widx), "R5 write slot", int'(mem_waddr), sbq[0].slot + widx);
          chk(busy && !req_ready, "R5 busy during clear", int'(busy), 1);
          chk(mem_wdata == 0, "R5 write data", int'(mem_wdata), 0);
          ram[mem_waddr] = 8'h00;
          widx++;
        end
      end
      if (req_err) begin
        chk(sbq.size() != 0 && sbq[0].err, "R6 err pulse", 1, 0);
        if (sbq.size() != 0) void'(sbq.pop_front());
      end
      if (rsp_valid) begin
        if (sbq.size() == 0 || sbq[0].err) chk(0, "R4 unexpected grant", int'(rsp_slot), -1);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(int'(rsp_slot) == e.slot, "R2/R3 start slot", int'(rsp_slot), e.slot);
          chk(e.slot + e.cnt <= CAP_M, "R3 run within pool", e.slot + e.cnt, CAP_M);
          chk(rsp_offset == 32'(e.slot * STRD), "R4/R7 offset", int'(rsp_offset), e.slot * STRD);
          chk(rsp_addr == 32'(BASE_M + e.slot * STRD), "R4 address", int'(rsp_addr), BASE_M + e.slot * STRD);
          chk(widx == e.cnt, "R5 write count", widx, e.cnt);
          for (int k = e.slot; k < e.slot + e.cnt && k < CAP_M; k++) begin
            chk(ram[k] == 8'h00, "R5 slot cleared", int'(ram[k]), 0);
            ram[k] = 8'hA5;
          end
        end
        widx = 0;
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    chk(0, "watchdog", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < CAP_M; k++) ram[k] = 8'hA5;
    req_valid = 0; req_count = 0; nq_slot = 0; s_nq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1, "R9 ready after reset", int'(req_ready), 1);
    chk(busy == 0 && rsp_valid == 0 && req_err == 0, "R9 idle after reset", int'(busy), 0);
    // R1 configuration rule
    chk(cfg_fault == 0, "R1 good set", int'(cfg_fault), 0);
    chk(b_fault == 1, "R1 bad set flagged", int'(b_fault), 1);
    chk(b_ready == 0, "R1 bad set refuses", int'(b_ready), 0);
    // R8 next-slot query
    s_nq = 3'd2; #1;
    chk(s_nqn == 3 && !s_nqe, "R8 next inside", int'(s_nqn), 3);
    s_nq = 3'd5; #1;
    chk(s_nqn == 0 && !s_nqe, "R8 wrap to zero", int'(s_nqn), 0);
    s_nq = 3'd6; #1;
    chk(s_nqe == 1, "R8 out of range", int'(s_nqe), 1);
    nq_slot = 4'd3; #1;
    chk(nq_err == 1, "R8 multi-slot pool", int'(nq_err), 1);
    chk(nq_next == 4, "R8 next value", int'(nq_next), 4);
    @(negedge clk);
    // grant sequence; the bench model predicts every start slot
    send(3);              // slot 0
    send(4);              // slot 3: offset 48 shows rounding (R7)
    send(0);              // R6 zero count
    send(5);              // R6 above MAX_RUN
    send(4);              // slot 7, proves pointer kept (R6)
    send(2);              // slot 11, ends exactly at CAP (R2)
    send(1);              // skip to slot 0 (R3)
    send(4);              // slot 1
    send(4);              // slot 5
    send(4);              // slot 9, exact end again (R2)
    send(3);              // slot 0 (R3)
    send(2);              // slot 3
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R5 all grants reported", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule